// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block watches over a processor's power and activity. It works entirely in the digital domain: a power-good level from an external comparator, a watchdog kick line driven by software and a chip-enable request arrive as inputs. The block produces two reset outputs of opposite polarity, an active-low watchdog flag and a gated chip-enable for memory. Every reset that is triggered is held for a fixed hold period. The watchdog fires when the kick line stops toggling. Memory chip-enable is blocked while reset is active, so a collapsing supply cannot corrupt a write. The one exception is a short grace window at the moment reset asserts, which lets a cycle already in flight complete.

A single-cycle tick from an internal prescaler is the time base for every period. The hold time, watchdog timeout and grace window are parameters counted in ticks, so one design covers real-time values (200 ms hold, 16 µs grace) and short values for simulation. The kick and chip-enable inputs pass through two-flop synchronizers. The power-good input is taken as already synchronous.

Top module: `reset_supervisor`

## Requirements
- R1: While the synchronous module reset `rstN` is low, and in the cycle after it, `resetN` is 0, `resetHi` is 1, `wdogFlagN` is 1 and `chipEnOutN` is 1. The prescaler restarts from zero.
- R2: A low `pwrGood` sampled at a clock edge drives `resetN` low at that edge. `resetN` stays low for as long as `pwrGood` stays low.
- R3: After reset is triggered, `resetN` returns high only once `pwrGood` has been high for HOLD_TICKS prescaler ticks. One tick occurs every PRESCALE clock cycles.
- R4: `resetHi` is at all times the inverse of `resetN`.
- R5: While reset is released, a rising or a falling edge of the synchronized `kickIn` restarts the watchdog. It expires after WDOG_TICKS ticks with no edge.
- R6: On expiry, `wdogFlagN` falls and `resetN` falls at the same clock edge. Reset is then held for the full hold period of R3.
- R7: Once `wdogFlagN` is low, it returns high only on the next edge of the synchronized `kickIn`. The release of reset does not clear it.
- R8: The watchdog count is held at zero while `resetN` is low and starts from zero when reset releases.
- R9: With `resetN` high, `chipEnOutN` follows the synchronized `chipEnIn`, two clocks after the pin. With `resetN` low and no grace window open, `chipEnOutN` is 1.
- R10: If the synchronized `chipEnIn` is low at the edge where `resetN` falls, a grace window opens for GRACE_TICKS ticks. During the window `chipEnOutN` stays low, and it goes high when the window ends.
- R11: The grace window closes early as soon as the synchronized `chipEnIn` is high. It does not reopen until the next assertion of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low module reset |
| pwrGood | input | 1 | Supply above threshold, synchronous, active high |
| kickIn | input | 1 | Watchdog kick; any edge restarts the timer |
| chipEnIn | input | 1 | Chip-enable request, active low |
| resetN | output | 1 | Reset to the processor, active low |
| resetHi | output | 1 | Reset to the processor, active high |
| wdogFlagN | output | 1 | Watchdog expired flag, active low |
| chipEnOutN | output | 1 | Gated chip-enable to memory, active low |

## Verification
The assertions check the cycle-level rules on every cycle. A low power-good forces reset on the next edge, and reset never releases without power-good. A falling watchdog flag always comes with reset. The flag stays low until a kick edge arrives. Chip-enable is blocked in reset outside the grace window, the window opens only at the reset edge, and it closes once chip-enable rises. Only the bench's scenarios can show the durations: the length of the hold, the watchdog timeout measured from the last edge of either polarity, the fact that the watchdog is idle during the hold, and the natural length of the grace window.

// File: rtl/reset_supervisor_pkg.sv
package reset_supervisor_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;
    logic holdRun;
    logic wdogClr;
    logic graceClr;
    logic graceRun;
  } supCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic tick;
    logic kickEdge;
    logic chipEnSync;
    logic holdDone;
    logic wdogLimit;
    logic graceDone;
  } supStat_t;

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= RST_VAL;
        else       stage[s] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= RST_VAL;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign qOut = stage[STAGES-1];

endmodule

// File: rtl/rs_tick_counter.sv
module rs_tick_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inc,
  output logic atLast
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      count <= '0;
    end else if (inc) begin
      count <= (count == LAST) ? '0 : count + 1'b1;
    end
  end

  assign atLast = (count == LAST);

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import reset_supervisor_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int HOLD_TICKS  = 8,
  parameter int WDOG_TICKS  = 10,
  parameter int GRACE_TICKS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    kickIn,
  input  logic    chipEnIn,
  input  supCtl_t ctl,
  output supStat_t stat
);

  localparam int PW = (PRESCALE < 2) ? 1 : $clog2(PRESCALE);
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  // tick prescaler; a divide-by-one variant needs no counter
  logic tick;
  if (PRESCALE < 2) begin : g_noPre
    assign tick = 1'b1;
  end else begin : g_pre
    logic [PW-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (!rstN)               preCnt <= '0;
      else if (preCnt == PLAST) preCnt <= '0;
      else                     preCnt <= preCnt + 1'b1;
    end
    assign tick = (preCnt == PLAST);
  end

  // input synchronizers: bit 1 kick (rests 0), bit 0 chip-enable (rests 1)
  logic [1:0] syncOut;
  rs_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2),
    .RST_VAL(2'b01)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn ({kickIn, chipEnIn}),
    .qOut(syncOut)
  );

  logic kickPrev;
  always_ff @(posedge clk) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= syncOut[1];
  end

  logic holdLast, wdogLast, graceLast;

  rs_tick_counter #(.LIMIT(HOLD_TICKS)) u_hold (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (ctl.holdClr),
    .inc   (ctl.holdRun & tick),
    .atLast(holdLast)
  );

  rs_tick_counter #(.LIMIT(WDOG_TICKS)) u_wdog (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (ctl.wdogClr),
    .inc   (tick),
    .atLast(wdogLast)
  );

  rs_tick_counter #(.LIMIT(GRACE_TICKS)) u_grace (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (ctl.graceClr),
    .inc   (ctl.graceRun & tick),
    .atLast(graceLast)
  );

  always_comb begin
    stat.tick       = tick;
    stat.kickEdge   = syncOut[1] ^ kickPrev;
    stat.chipEnSync = syncOut[0];
    stat.holdDone   = tick & holdLast;
    stat.wdogLimit  = tick & wdogLast;
    stat.graceDone  = tick & graceLast;
  end

endmodule

// File: rtl/rs_control.sv
module rs_control
  import reset_supervisor_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrGood,
  input  supStat_t stat,
  output supCtl_t  ctl,
  output logic     resetN,
  output logic     resetHi,
  output logic     wdogFlagN,
  output logic     chipEnOutN
);

  logic rstOut;       // 1 = reset released
  logic flagN;
  logic graceActive;

  logic wdogExpire, assertReq, graceStart, graceEnd;

  always_comb begin
    wdogExpire = rstOut & stat.wdogLimit & ~stat.kickEdge;
    assertReq  = ~pwrGood | wdogExpire;
    graceStart = rstOut & assertReq & ~stat.chipEnSync;
    graceEnd   = graceActive & (stat.chipEnSync | stat.graceDone);

    ctl.holdClr  = rstOut | assertReq;
    ctl.holdRun  = ~rstOut;
    ctl.wdogClr  = ~rstOut | assertReq | stat.kickEdge;
    ctl.graceClr = graceStart | ~graceActive;
    ctl.graceRun = graceActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstOut      <= 1'b0;
      flagN       <= 1'b1;
      graceActive <= 1'b0;
    end else begin
      if (assertReq)                     rstOut <= 1'b0;
      else if (!rstOut && stat.holdDone) rstOut <= 1'b1;

      if (wdogExpire)         flagN <= 1'b0;
      else if (stat.kickEdge) flagN <= 1'b1;

      if (graceStart)    graceActive <= 1'b1;
      else if (graceEnd) graceActive <= 1'b0;
    end
  end

  assign resetN     = rstOut;
  assign resetHi    = ~rstOut;
  assign wdogFlagN  = flagN;
  assign chipEnOutN = ~(~stat.chipEnSync & (rstOut | graceActive));

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import reset_supervisor_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int HOLD_TICKS  = 8,
  parameter int WDOG_TICKS  = 10,
  parameter int GRACE_TICKS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic kickIn,
  input  logic chipEnIn,
  output logic resetN,
  output logic resetHi,
  output logic wdogFlagN,
  output logic chipEnOutN
);

  supCtl_t  dpCtl;
  supStat_t dpStat;

  rs_datapath #(
    .PRESCALE   (PRESCALE),
    .HOLD_TICKS (HOLD_TICKS),
    .WDOG_TICKS (WDOG_TICKS),
    .GRACE_TICKS(GRACE_TICKS),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .kickIn  (kickIn),
    .chipEnIn(chipEnIn),
    .ctl     (dpCtl),
    .stat    (dpStat)
  );

  rs_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrGood   (pwrGood),
    .stat      (dpStat),
    .ctl       (dpCtl),
    .resetN    (resetN),
    .resetHi   (resetHi),
    .wdogFlagN (wdogFlagN),
    .chipEnOutN(chipEnOutN)
  );

endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic pwrGood,
  input logic resetN,
  input logic wdogFlagN,
  input logic chipEnOutN,
  input logic kickEdge,
  input logic chipEnSync,
  input logic graceActive
);

  AST_PG_FORCES_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> !resetN); // R2

  AST_RELEASE_NEEDS_PG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(pwrGood)); // R3

  AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdogFlagN) |-> !resetN); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!wdogFlagN && !kickEdge) |=> !wdogFlagN); // R7

  AST_CE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!resetN && !graceActive) |-> chipEnOutN); // R9

  AST_GRACE_AT_ASSERT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(graceActive) |-> $fell(resetN)); // R10

  AST_GRACE_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (graceActive && chipEnSync) |=> !graceActive); // R11

endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pwrGood    (pwrGood),
  .resetN     (resetN),
  .wdogFlagN  (wdogFlagN),
  .chipEnOutN (chipEnOutN),
  .kickEdge   (dpStat.kickEdge),
  .chipEnSync (dpStat.chipEnSync),
  .graceActive(u_ctl.graceActive)
);

// File: tb/reset_supervisor_tb.sv
`timescale 1ns/1ps
module reset_supervisor_tb;

  localparam int SIG_RSTN = 0, SIG_RSTHI = 1, SIG_FLAG = 2, SIG_CE = 3;

  typedef struct {
    int    when;
    int    sig;
    logic  val;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrGood = 1'b1, kickIn = 1'b0, chipEnIn = 1'b1;
  logic resetN, resetHi, wdogFlagN, chipEnOutN;

  int cyc = 0;
  int applied = 0;
  int miscompares = 0;
  bit autoKick = 1'b0;
  int kickReq = 0;
  int kickSeen = 0;
  int kickCnt = 0;
  expItem_t sbq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reset_supervisor #(
    .PRESCALE(4), .HOLD_TICKS(8), .WDOG_TICKS(10), .GRACE_TICKS(5)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .kickIn(kickIn),
    .chipEnIn(chipEnIn), .resetN(resetN), .resetHi(resetHi),
    .wdogFlagN(wdogFlagN), .chipEnOutN(chipEnOutN)
  );

  // kick generator: periodic toggles when enabled, plus single requests
  always @(negedge clk) begin
    if (kickReq != kickSeen) begin
      kickSeen = kickReq;
      kickIn   = ~kickIn;
      kickCnt  = 0;
    end else if (autoKick) begin
      if (kickCnt == 0) kickIn = ~kickIn;
      kickCnt = (kickCnt == 23) ? 0 : kickCnt + 1;
    end else begin
      kickCnt = 0;
    end
  end

  // driver side of the scoreboard
  task automatic expectIn(input int d, input int sig, input logic val, input string req);
    expItem_t it;
    it.when = cyc + d;
    it.sig  = sig;
    it.val  = val;
    it.req  = req;
    sbq.push_back(it);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic sample(input int sig);
    case (sig)
      SIG_RSTN:  return resetN;
      SIG_RSTHI: return resetHi;
      SIG_FLAG:  return wdogFlagN;
      default:   return chipEnOutN;
    endcase
  endfunction

  // monitor side of the scoreboard
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].when == cyc) begin
        logic act;
        act = sample(sbq[i].sig);
        applied++;
        if (act !== sbq[i].val) begin
          miscompares++;
          $display("FAIL %s: signal %0d at cycle %0d actual %b expected %b",
                   sbq[i].req, sbq[i].sig, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: module reset state
    waitCyc(2);
    expectIn(1, SIG_RSTN, 1'b0, "R1");
    expectIn(1, SIG_RSTHI, 1'b1, "R1");
    expectIn(1, SIG_FLAG, 1'b1, "R1");
    expectIn(1, SIG_CE, 1'b1, "R1");
    waitCyc(3);
    rstN = 1'b1;
    // R3 power-up hold, R4 polarity, R8 watchdog idle during hold
    expectIn(20, SIG_RSTN, 1'b0, "R3");
    expectIn(20, SIG_RSTHI, 1'b1, "R4");
    expectIn(44, SIG_RSTN, 1'b1, "R3");
    expectIn(44, SIG_RSTHI, 1'b0, "R4");
    expectIn(62, SIG_FLAG, 1'b1, "R8");
    waitCyc(63);
    autoKick = 1'b1;

    // R5: alternating edges 24 cycles apart keep the watchdog quiet
    expectIn(100, SIG_FLAG, 1'b1, "R5");
    expectIn(200, SIG_FLAG, 1'b1, "R5");
    expectIn(200, SIG_RSTN, 1'b1, "R5");
    waitCyc(202);

    // R9: gating while running
    chipEnIn = 1'b0;
    expectIn(4, SIG_CE, 1'b0, "R9");
    waitCyc(6);
    chipEnIn = 1'b1;
    expectIn(4, SIG_CE, 1'b1, "R9");
    waitCyc(6);

    // R5/R6/R7: stall the kick line after one final edge
    autoKick = 1'b0;
    waitCyc(2);
    kickReq++;
    expectIn(30, SIG_FLAG, 1'b1, "R5");
    expectIn(50, SIG_FLAG, 1'b0, "R6");
    expectIn(50, SIG_RSTN, 1'b0, "R6");
    expectIn(60, SIG_RSTN, 1'b0, "R6");
    expectIn(95, SIG_RSTN, 1'b1, "R6");
    expectIn(95, SIG_FLAG, 1'b0, "R7");
    waitCyc(97);
    kickReq++;
    expectIn(5, SIG_FLAG, 1'b1, "R7");
    waitCyc(2);
    autoKick = 1'b1;
    waitCyc(10);

    // R2/R3: power-good drop and recovery
    pwrGood = 1'b0;
    expectIn(2, SIG_RSTN, 1'b0, "R2");
    expectIn(90, SIG_RSTN, 1'b0, "R2");
    waitCyc(100);
    pwrGood = 1'b1;
    expectIn(20, SIG_RSTN, 1'b0, "R3");
    expectIn(44, SIG_RSTN, 1'b1, "R3");
    waitCyc(50);

    // R10: grace window runs its full length
    chipEnIn = 1'b0;
    waitCyc(6);
    pwrGood = 1'b0;
    expectIn(12, SIG_RSTN, 1'b0, "R10");
    expectIn(12, SIG_CE, 1'b0, "R10");
    expectIn(26, SIG_CE, 1'b1, "R10");
    waitCyc(30);
    chipEnIn = 1'b1;
    pwrGood = 1'b1;
    waitCyc(50);

    // R11: grace closes early and stays closed
    chipEnIn = 1'b0;
    waitCyc(6);
    pwrGood = 1'b0;
    waitCyc(3);
    chipEnIn = 1'b1;
    expectIn(4, SIG_CE, 1'b1, "R11");
    waitCyc(5);
    chipEnIn = 1'b0;
    expectIn(5, SIG_CE, 1'b1, "R11");
    waitCyc(8);
    chipEnIn = 1'b1;
    pwrGood = 1'b1;
    waitCyc(50);

    if (sbq.size() != 0) begin
      miscompares += sbq.size();
      $display("FAIL R1: actual %0d unmatched expectations expected 0", sbq.size());
    end
    finishRun();
  end

endmodule